// File: doc/BRIEF.md
# Quadword Load/Store Memory Sequencer

This block carries out 128-bit load and store operations for a core whose register file and memory port are only 32 bits wide. When an operation is issued it forms the effective address as a base value plus a sign-extended 16-bit offset. It then checks alignment and either raises an address-error exception or runs a request/wait exchange with a 32-bit memory port.

A quadword store is broken into four word writes at rising addresses. The low word is the register value, and the three upper words come from a shadow input. A quadword load performs one read of the low word and writes it back to the destination register. The upper 96 bits have no place to live, so they are never fetched. A plain word load shares the same path so that the two can be compared.

The state machine has three states. `S_IDLE` waits for `start`. Taking an aligned operation moves it `S_IDLE -> S_REQ`, while a fault keeps it in `S_IDLE` and posts the exception. `S_REQ` holds the request until `mem_ready` and then moves `S_REQ -> S_WAIT`. In `S_WAIT` a load's data is written back and the operation completes (`S_WAIT -> S_IDLE`). A store with beats left to send goes back to the request state (`S_WAIT -> S_REQ`), and after its fourth beat it completes (`S_WAIT -> S_IDLE`).

Top module: `qmem_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_req`, `done`, `wb_en` and `exc_valid` are all 0.
- R2: The effective address equals `base` plus `offset` sign-extended from bit 15 to 32 bits. A negative offset subtracts from the base.
- R3: `acc_kind` selects the operation: 2'b00 is word load, 2'b01 is quadword load and 2'b10 is quadword store. A `start` with 2'b11 is ignored, with no memory access, no writeback, no done and no exception.
- R4: A quadword access whose effective address has a nonzero value in bits [3:0] faults, and so does a word load with a nonzero value in bits [1:0]. On a fault, `exc_valid` pulses for one cycle and `exc_code` is 5 for a store or 4 for a load. `badaddr` holds the faulting address until the next fault, and no memory request is made.
- R5: A quadword store issues exactly four write beats. Beat n goes to address ea+4n with data word n. Word 0 is `rt_val` and words 1, 2 and 3 are `rt_hi[31:0]`, `rt_hi[63:32]` and `rt_hi[95:64]`. All operands are captured when the operation is taken.
- R6: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, on every cycle until `mem_ready` is seen high alongside it.
- R7: A quadword or word load makes one read at the effective address and writes the returned word to register `rt_idx` through `wb_en`/`wb_idx`/`wb_data`. An aligned quadword load returns the same value as a word load from that address.
- R8: A load whose destination is register 0 still performs its read and completes, but `wb_en` stays low.
- R9: `done` is high for exactly one cycle per completed operation, in the cycle after the last beat is accepted, which is the same cycle as any writeback. `busy` is high from the cycle after the operation is taken until that done cycle. A `start` or input change while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue an operation (sampled while idle) |
| acc_kind | input | 2 | Operation select (see R3) |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed immediate offset |
| rt_idx | input | 5 | Destination register number for loads |
| rt_val | input | 32 | Low word of store data |
| rt_hi | input | 96 | Upper three words of store data (shadow input) |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| wb_en | output | 1 | Register writeback strobe |
| wb_idx | output | 5 | Writeback register number |
| wb_data | output | 32 | Writeback data |
| done | output | 1 | Operation complete pulse |
| exc_valid | output | 1 | Address-error exception pulse |
| exc_code | output | 5 | Exception code: 4 load, 5 store |
| badaddr | output | 32 | Last faulting address |

## Verification
Stores run with a positive offset and zero memory latency, and again with a negative offset and several wait cycles. The first shows the beat order and word selection. The second shows that the address sums correctly and that the request holds steady under stalls. A quadword load and then a word load read the stored location, which tells a correct low-word writeback apart from a wrong lane or a lost cross-check. Misaligned addresses in bits 3, 2 and 1 separate the quadword and word alignment rules and the load and store codes. Loads to register 0, the unused kind, and a start held high with scrambled operands mid-operation show suppressed writeback, ignored issue, and operand capture.

// File: rtl/qmem_pkg.sv
package qmem_pkg;

    typedef enum logic [1:0] {
        ACC_LW   = 2'b00,
        ACC_LQ   = 2'b01,
        ACC_SQ   = 2'b10,
        ACC_NONE = 2'b11
    } acc_kind_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_REQ,
        S_WAIT
    } seq_state_t;

    localparam logic [4:0] EXC_ADDR_LOAD  = 5'd4;
    localparam logic [4:0] EXC_ADDR_STORE = 5'd5;

endpackage

// File: rtl/qmem_agen.sv
module qmem_agen
    import qmem_pkg::*;
#(
    parameter int AW     = 32,
    parameter int OW     = 16,
    parameter int DW     = 32,
    parameter int NBEATS = 4
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] offset,
    input  acc_kind_t     kind,
    output logic [AW-1:0] ea,
    output logic          misalign
);
    localparam int WALIGN = $clog2(DW / 8);
    localparam int QALIGN = $clog2(NBEATS * DW / 8);

    logic [AW-1:0] off_ext;

    assign off_ext = {{(AW-OW){offset[OW-1]}}, offset};
    assign ea      = base + off_ext;

    always_comb begin
        if (kind == ACC_LW) misalign = |ea[WALIGN-1:0];
        else                misalign = |ea[QALIGN-1:0];
    end
endmodule

// File: rtl/qmem_beatsel.sv
module qmem_beatsel #(
    parameter int DW     = 32,
    parameter int NBEATS = 4
) (
    input  logic [NBEATS*DW-1:0]       words,
    input  logic [$clog2(NBEATS)-1:0]  beat,
    output logic [DW-1:0]              word
);
    logic [DW-1:0] lane [NBEATS];

    for (genvar g = 0; g < NBEATS; g++) begin : g_lane
        assign lane[g] = words[g*DW +: DW];
    end

    assign word = lane[beat];
endmodule

// File: rtl/qmem_fsm.sv
module qmem_fsm
    import qmem_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int RW     = 5,
    parameter int NBEATS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  acc_kind_t                 kind,
    input  logic [AW-1:0]             ea,
    input  logic                      misalign,
    input  logic [RW-1:0]             rt_idx,
    input  logic                      mem_ready,
    input  logic [DW-1:0]             mem_rdata,
    output logic                      accept,
    output logic [$clog2(NBEATS)-1:0] beat,
    output logic                      busy,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [AW-1:0]             mem_addr,
    output logic                      wb_en,
    output logic [RW-1:0]             wb_idx,
    output logic [DW-1:0]             wb_data,
    output logic                      done,
    output logic                      exc_valid,
    output logic [4:0]                exc_code,
    output logic [AW-1:0]             badaddr
);
    localparam int BW     = $clog2(NBEATS);
    localparam int WALIGN = $clog2(DW / 8);

    seq_state_t    state, nxt;
    logic [AW-1:0] ea_q;
    acc_kind_t     kind_q;
    logic [RW-1:0] idx_q;
    logic [DW-1:0] rdata_q;
    logic [BW-1:0] beat_q;
    logic          exc_q;
    logic [4:0]    code_q;
    logic [AW-1:0] bad_q;

    logic go, fault, last;

    assign go     = start && (kind != ACC_NONE) && (state == S_IDLE);
    assign fault  = go && misalign;
    assign accept = go && !misalign;
    assign last   = (kind_q != ACC_SQ) || (beat_q == BW'(NBEATS - 1));

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (accept)    nxt = S_REQ;
            S_REQ:   if (mem_ready) nxt = S_WAIT;
            S_WAIT:  nxt = last ? S_IDLE : S_REQ;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // operand, beat and exception registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q    <= '0;
            kind_q  <= ACC_LW;
            idx_q   <= '0;
            rdata_q <= '0;
            beat_q  <= '0;
            exc_q   <= 1'b0;
            code_q  <= '0;
            bad_q   <= '0;
        end else begin
            exc_q <= fault;
            if (fault) begin
                code_q <= (kind == ACC_SQ) ? EXC_ADDR_STORE : EXC_ADDR_LOAD;
                bad_q  <= ea;
            end
            if (accept) begin
                ea_q   <= ea;
                kind_q <= kind;
                idx_q  <= rt_idx;
                beat_q <= '0;
            end
            if (state == S_REQ && mem_ready && kind_q != ACC_SQ)
                rdata_q <= mem_rdata;
            if (state == S_WAIT && !last)
                beat_q <= beat_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        mem_req   = (state == S_REQ);
        mem_we    = mem_req && (kind_q == ACC_SQ);
        mem_addr  = ea_q + (AW'(beat_q) << WALIGN);
        beat      = beat_q;
        wb_en     = (state == S_WAIT) && (kind_q != ACC_SQ) && (idx_q != '0);
        wb_idx    = idx_q;
        wb_data   = rdata_q;
        done      = (state == S_WAIT) && last;
        exc_valid = exc_q;
        exc_code  = code_q;
        badaddr   = bad_q;
    end
endmodule

// File: rtl/qmem_seq.sv
module qmem_seq
    import qmem_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int OW     = 16,
    parameter int RW     = 5,
    parameter int NBEATS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               acc_kind,
    input  logic [AW-1:0]            base,
    input  logic [OW-1:0]            offset,
    input  logic [RW-1:0]            rt_idx,
    input  logic [DW-1:0]            rt_val,
    input  logic [(NBEATS-1)*DW-1:0] rt_hi,
    output logic                     busy,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [AW-1:0]            mem_addr,
    output logic [DW-1:0]            mem_wdata,
    input  logic                     mem_ready,
    input  logic [DW-1:0]            mem_rdata,
    output logic                     wb_en,
    output logic [RW-1:0]            wb_idx,
    output logic [DW-1:0]            wb_data,
    output logic                     done,
    output logic                     exc_valid,
    output logic [4:0]               exc_code,
    output logic [AW-1:0]            badaddr
);
    localparam int BW = $clog2(NBEATS);
    localparam int QW = NBEATS * DW;

    acc_kind_t     kind;
    logic [AW-1:0] ea;
    logic          misalign;
    logic          accept;
    logic [BW-1:0] beat;
    logic [QW-1:0] words_q;

    assign kind = acc_kind_t'(acc_kind);

    qmem_agen #(.AW(AW), .OW(OW), .DW(DW), .NBEATS(NBEATS)) u_agen (
        .base     (base),
        .offset   (offset),
        .kind     (kind),
        .ea       (ea),
        .misalign (misalign)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      words_q <= '0;
        else if (accept) words_q <= {rt_hi, rt_val};
    end

    qmem_beatsel #(.DW(DW), .NBEATS(NBEATS)) u_sel (
        .words (words_q),
        .beat  (beat),
        .word  (mem_wdata)
    );

    qmem_fsm #(.AW(AW), .DW(DW), .RW(RW), .NBEATS(NBEATS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .kind      (kind),
        .ea        (ea),
        .misalign  (misalign),
        .rt_idx    (rt_idx),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .accept    (accept),
        .beat      (beat),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .wb_en     (wb_en),
        .wb_idx    (wb_idx),
        .wb_data   (wb_data),
        .done      (done),
        .exc_valid (exc_valid),
        .exc_code  (exc_code),
        .badaddr   (badaddr)
    );
endmodule

// File: rtl/qmem_seq_chk.sv
module qmem_seq_chk #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int RW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_ready,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          wb_en,
    input logic [RW-1:0] wb_idx,
    input logic          done,
    input logic          exc_valid
);
    a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    a_r4_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (!busy && !mem_req));

    a_r5_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r7_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    a_r8_no_r0_write: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_idx != '0));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind qmem_seq qmem_seq_chk #(.AW(AW), .DW(DW), .RW(RW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .wb_en     (wb_en),
    .wb_idx    (wb_idx),
    .done      (done),
    .exc_valid (exc_valid)
);

// File: tb/sim_qmem_seq.sv
`timescale 1ns/1ps
module sim_qmem_seq;
    localparam int EV_WR = 0, EV_RD = 1, EV_WB = 2, EV_DONE = 3, EV_EXC = 4;

    typedef struct {
        int          k;
        logic [31:0] a;
        logic [31:0] d;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  acc_kind = 2'b00;
    logic [31:0] base = '0;
    logic [15:0] offset = '0;
    logic [4:0]  rt_idx = '0;
    logic [31:0] rt_val = '0;
    logic [95:0] rt_hi = '0;
    logic        busy, mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        wb_en, done, exc_valid;
    logic [4:0]  wb_idx, exc_code;
    logic [31:0] wb_data, badaddr;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int lat = 0;
    int n_mem = 0;
    logic [3:0]  wcnt = '0;
    logic [31:0] bmem [0:255];
    logic [31:0] last_wb = '0;
    ev_t exp_q[$];

    always #10 clk = ~clk;

    qmem_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .acc_kind(acc_kind),
        .base(base), .offset(offset), .rt_idx(rt_idx), .rt_val(rt_val),
        .rt_hi(rt_hi), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_idx(wb_idx),
        .wb_data(wb_data), .done(done), .exc_valid(exc_valid),
        .exc_code(exc_code), .badaddr(badaddr)
    );

    // memory responder
    assign mem_ready = mem_req && (int'(wcnt) >= lat);
    assign mem_rdata = mem_ready ? bmem[mem_addr[9:2]] : 32'h0;

    always @(posedge clk) begin
        if (mem_req && !mem_ready) wcnt <= wcnt + 4'd1;
        else                       wcnt <= '0;
        if (mem_req && mem_ready && mem_we) bmem[mem_addr[9:2]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input int k, input logic [31:0] a, input logic [31:0] d);
        ev_t e;
        e.k = k; e.a = a; e.d = d;
        exp_q.push_back(e);
    endtask

    task automatic observe(input int k, input logic [31:0] a, input logic [31:0] d);
        ev_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R9 unexpected event (R3/R4/R8)", a, 32'(k));
        end else begin
            e = exp_q.pop_front();
            chk(e.k == k, "R5/R7 event kind", 32'(k), 32'(e.k));
            chk(e.a == a, "R2/R5 event address", a, e.a);
            chk(e.d == d, "R5/R7 event data", d, e.d);
        end
    endtask

    // monitor
    logic [31:0] h_addr = '0, h_data = '0;
    int hcnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) begin
                if (hcnt > 0) begin
                    chk(mem_addr == h_addr, "R6 address held", mem_addr, h_addr);
                    chk(mem_wdata == h_data, "R6 data held", mem_wdata, h_data);
                end
                if (!mem_ready) begin
                    h_addr = mem_addr; h_data = mem_wdata; hcnt++;
                end else begin
                    hcnt = 0;
                    n_mem++;
                    observe(mem_we ? EV_WR : EV_RD, mem_addr, mem_we ? mem_wdata : 32'h0);
                end
            end
            if (wb_en) begin
                last_wb = wb_data;
                observe(EV_WB, {27'h0, wb_idx}, wb_data);
            end
            if (done)      observe(EV_DONE, 32'h0, 32'h0);
            if (exc_valid) observe(EV_EXC, badaddr, {27'h0, exc_code});
        end
    end

    task automatic do_op(input logic [1:0] k, input logic [31:0] b, input logic [15:0] off,
                         input logic [4:0] idx, input logic [31:0] v, input logic [95:0] hi,
                         input int l, input bit hold);
        logic [31:0] ea;
        bit mis;
        ea  = b + {{16{off[15]}}, off};
        mis = (k == 2'b00) ? (ea[1:0] != 0) : (ea[3:0] != 0);
        lat = l;
        if (k == 2'b11) begin
        end else if (mis) begin
            push(EV_EXC, ea, (k == 2'b10) ? 32'd5 : 32'd4);
        end else if (k == 2'b10) begin
            push(EV_WR, ea,      v);
            push(EV_WR, ea + 4,  hi[31:0]);
            push(EV_WR, ea + 8,  hi[63:32]);
            push(EV_WR, ea + 12, hi[95:64]);
            push(EV_DONE, 32'h0, 32'h0);
        end else begin
            push(EV_RD, ea, 32'h0);
            if (idx != 0) push(EV_WB, {27'h0, idx}, bmem[ea[9:2]]);
            push(EV_DONE, 32'h0, 32'h0);
        end
        @(negedge clk);
        acc_kind = k; base = b; offset = off; rt_idx = idx; rt_val = v; rt_hi = hi;
        start = 1'b1;
        @(negedge clk);
        if (!hold) start = 1'b0;
        else begin
            rt_val = ~v; rt_hi = ~hi; base = b + 32'h40; rt_idx = idx ^ 5'h1f;
        end
        while (busy) @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int m0;
        for (int i = 0; i < 256; i++) bmem[i] = 32'h1000_0000 + 32'(i * 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0,      "R1 busy",      32'(busy), 0);
        chk(mem_req == 0,   "R1 mem_req",   32'(mem_req), 0);
        chk(done == 0,      "R1 done",      32'(done), 0);
        chk(wb_en == 0,     "R1 wb_en",     32'(wb_en), 0);
        chk(exc_valid == 0, "R1 exc_valid", 32'(exc_valid), 0);

        // R5 R2: store, positive offset, no latency
        do_op(2'b10, 32'h100, 16'h0020, 5'd3, 32'hA5A5_0001,
              {32'hA5A5_0004, 32'hA5A5_0003, 32'hA5A5_0002}, 0, 1'b0);
        // R2 R6: negative offset, stalled memory
        do_op(2'b10, 32'h240, 16'hFFC0, 5'd3, 32'h5A5A_1111,
              {32'h5A5A_4444, 32'h5A5A_3333, 32'h5A5A_2222}, 3, 1'b0);
        chk(bmem[32'h200 >> 2] == 32'h5A5A_1111, "R2 store landed", bmem[32'h200 >> 2], 32'h5A5A_1111);

        // R7 quadword load then word load, same address
        do_op(2'b01, 32'h100, 16'h0020, 5'd9, 32'h0, 96'h0, 1, 1'b0);
        chk(last_wb == 32'hA5A5_0001, "R7 quad load value", last_wb, 32'hA5A5_0001);
        do_op(2'b00, 32'h120, 16'h0000, 5'd10, 32'h0, 96'h0, 2, 1'b0);
        chk(last_wb == 32'hA5A5_0001, "R7 word load matches", last_wb, 32'hA5A5_0001);

        // R4 faults: no memory access
        m0 = n_mem;
        do_op(2'b01, 32'h120, 16'h0008, 5'd9, 32'h0, 96'h0, 0, 1'b0);
        chk(badaddr == 32'h128, "R4 load badaddr", badaddr, 32'h128);
        chk(exc_code == 5'd4,   "R4 load code", 32'(exc_code), 4);
        do_op(2'b10, 32'h100, 16'h0004, 5'd3, 32'h77, 96'h0, 0, 1'b0);
        chk(badaddr == 32'h104, "R4 store badaddr", badaddr, 32'h104);
        chk(exc_code == 5'd5,   "R4 store code", 32'(exc_code), 5);
        do_op(2'b00, 32'h100, 16'h0002, 5'd4, 32'h0, 96'h0, 0, 1'b0);
        chk(badaddr == 32'h102, "R4 word badaddr", badaddr, 32'h102);
        chk(n_mem == m0, "R4 no access on fault", 32'(n_mem), 32'(m0));
        // word load 4-aligned but not 16-aligned is legal
        do_op(2'b00, 32'h120, 16'h0004, 5'd5, 32'h0, 96'h0, 0, 1'b0);
        chk(last_wb == 32'hA5A5_0002, "R4 word load at +4", last_wb, 32'hA5A5_0002);

        // R8 load to r0
        m0 = n_mem;
        last_wb = 32'hDEAD_0000;
        do_op(2'b01, 32'h200, 16'h0000, 5'd0, 32'h0, 96'h0, 1, 1'b0);
        chk(n_mem == m0 + 1, "R8 read still made", 32'(n_mem), 32'(m0 + 1));
        chk(last_wb == 32'hDEAD_0000, "R8 no writeback", last_wb, 32'hDEAD_0000);

        // R3 unused kind ignored
        m0 = n_mem;
        do_op(2'b11, 32'h100, 16'h0000, 5'd7, 32'h1, 96'h0, 0, 1'b0);
        chk(busy == 0 && n_mem == m0, "R3 kind 11 ignored", 32'(n_mem), 32'(m0));

        // R9 start held and operands scrambled while busy
        do_op(2'b10, 32'h300, 16'h0000, 5'd1, 32'hC0DE_0000,
              {32'hC0DE_0003, 32'hC0DE_0002, 32'hC0DE_0001}, 2, 1'b1);
        chk(busy == 0, "R9 idle after op", 32'(busy), 0);
        chk(bmem[32'h30C >> 2] == 32'hC0DE_0003, "R5 top word captured",
            bmem[32'h30C >> 2], 32'hC0DE_0003);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all expected events seen", 32'(exp_q.size()), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule